// File: doc/BRIEF.md
# Replica-Banked One-Read One-Write Memory

This block is a single-clock memory with one read port and one write port, both usable in every cycle. Storage is built only from single-port banks: the logical address space is split into a lower and an upper half, each half-sized bank holds one half's worth of rows, and a third bank of the same size is kept spare. A per-row remap table records which physical bank currently holds each logical half of that row. The spare bank for a row is whichever bank that row's two halves are not using.

When a read and a write in the same cycle land on the same physical bank, the write is steered into that row's spare bank and the table entry for the written half is updated. The bank the write left behind becomes the new spare for that row. The read proceeds untouched, so both operations finish in the same cycle with no stall or retry signal. Read data is registered and appears one cycle after the read request. A read and a write to the same address in one cycle return the previous contents. Both ports share one clock.

Top module: `replica_rw_mem`

## Requirements
- R1: A read of any address, in either half, returns the data most recently written to that address.
- R2: `rd_valid` is high, and `rd_data` carries the read result, in the cycle after a cycle with `rd_en` high.
- R3: A read and a write may be issued in every cycle, including when both map to the same physical bank; no stall or retry exists and the written data is returned by later reads.
- R4: A read and a write to the same address in the same cycle return the old data; the next read of that address returns the new data.
- R5: After reset `rd_valid` is 0 and `rd_data` is 0, and every row maps its lower half to bank 0, its upper half to bank 1, leaving bank 2 spare.
- R6: After a redirected write, the two halves of every row stay in two distinct banks; repeated redirections on one row never disturb the other half of that row.
- R7: A cycle with `rd_en` low leaves `rd_valid` low in the next cycle and `rd_data` unchanged.
- R8: A cycle with `wr_en` low changes no stored word, whatever `wr_addr` and `wr_data` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address; top bit selects the half, the rest the row |
| rd_data | output | DATA_W | Read result, one cycle after the request |
| rd_valid | output | 1 | High in the cycle `rd_data` holds a new result |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write address; top bit selects the half, the rest the row |
| wr_data | input | DATA_W | Word to store |

## Verification
The hardest state to reach from the ports is a row whose halves have been shuffled by several redirections, so that its spare has moved away from bank 2 and the lookup for one half points at a bank that another row still uses in its original place. The stimulus gets there by pairing reads and writes in the same half on chosen rows right after a full fill, then repeatedly clashing on one row from both halves, and finally running long random traffic whose addresses are drawn from a few rows with matching half bits, so that redirections pile up on the same rows while every read is compared with a reference copy.

// File: rtl/rrw_pkg.sv
package rrw_pkg;

    localparam int NBANK = 3;

    typedef logic [1:0] bank_t;

    // Physical location of both logical halves of one row
    typedef struct packed {
        bank_t hi;
        bank_t lo;
    } rowmap_t;

    localparam rowmap_t MAP_INIT = '{hi: 2'd1, lo: 2'd0};

    // The bank unused by a row: bank ids sum to 3
    function automatic bank_t spare_of(rowmap_t m);
        return bank_t'(2'd3 - m.lo - m.hi);
    endfunction

    function automatic bank_t half_loc(rowmap_t m, logic half);
        return half ? m.hi : m.lo;
    endfunction

endpackage

// File: rtl/rrw_bank.sv
module rrw_bank #(
    parameter int ROW_W  = 7,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int ROWS = 1 << ROW_W;

    logic [DATA_W-1:0] cells [ROWS];

    // Single port: one access per cycle, either store or fetch
    always_ff @(posedge clk) begin
        if (en && we) begin
            cells[row] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (en && !we) begin
            rdata <= cells[row];
        end
    end

endmodule

// File: rtl/rrw_map_table.sv
module rrw_map_table
    import rrw_pkg::*;
#(
    parameter int ROW_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ROW_W-1:0] rd_row,
    input  logic [ROW_W-1:0] wr_row,
    output rowmap_t          rd_map,
    output rowmap_t          wr_map,
    input  logic             upd_en,
    input  logic [ROW_W-1:0] upd_row,
    input  logic             upd_half,
    input  bank_t            upd_bank
);
    localparam int ROWS = 1 << ROW_W;

    rowmap_t map_q [ROWS];

    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            always_ff @(posedge clk) begin
                if (rst) begin
                    map_q[r] <= MAP_INIT;
                end else if (upd_en && (upd_row == ROW_W'(r))) begin
                    if (upd_half) begin
                        map_q[r].hi <= upd_bank;
                    end else begin
                        map_q[r].lo <= upd_bank;
                    end
                end
            end
        end
    endgenerate

    assign rd_map = map_q[rd_row];
    assign wr_map = map_q[wr_row];

endmodule

// File: rtl/rrw_steer.sv
module rrw_steer
    import rrw_pkg::*;
(
    input  logic    rd_en,
    input  logic    wr_en,
    input  logic    rd_half,
    input  logic    wr_half,
    input  rowmap_t rd_map,
    input  rowmap_t wr_map,
    output bank_t   rd_bank,
    output bank_t   wr_bank,
    output logic    redirect
);
    bank_t wr_home;

    always_comb begin
        rd_bank  = half_loc(rd_map, rd_half);
        wr_home  = half_loc(wr_map, wr_half);
        redirect = rd_en && wr_en && (wr_home == rd_bank);
        wr_bank  = redirect ? spare_of(wr_map) : wr_home;
    end

endmodule

// File: rtl/rrw_rd_route.sv
module rrw_rd_route
    import rrw_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  bank_t             rd_bank,
    input  logic [DATA_W-1:0] bank_rdata [NBANK],
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    bank_t sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q    <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                sel_q <= rd_bank;
            end
        end
    end

    always_comb begin
        rd_data = bank_rdata[0];
        for (int b = 1; b < NBANK; b++) begin
            if (sel_q == bank_t'(b)) begin
                rd_data = bank_rdata[b];
            end
        end
    end

endmodule

// File: rtl/replica_rw_mem.sv
module replica_rw_mem
    import rrw_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int ROW_W = ADDR_W - 1;

    logic              rd_half, wr_half;
    logic [ROW_W-1:0]  rd_row, wr_row;
    rowmap_t           rd_map, wr_map;
    bank_t             rd_bank, wr_bank;
    logic              redirect;
    logic [DATA_W-1:0] bank_rdata [NBANK];

    assign rd_half = rd_addr[ADDR_W-1];
    assign wr_half = wr_addr[ADDR_W-1];
    assign rd_row  = rd_addr[ROW_W-1:0];
    assign wr_row  = wr_addr[ROW_W-1:0];

    rrw_map_table #(.ROW_W(ROW_W)) table_i (
        .clk      (clk),
        .rst      (rst),
        .rd_row   (rd_row),
        .wr_row   (wr_row),
        .rd_map   (rd_map),
        .wr_map   (wr_map),
        .upd_en   (redirect),
        .upd_row  (wr_row),
        .upd_half (wr_half),
        .upd_bank (wr_bank)
    );

    rrw_steer steer_i (
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .rd_half  (rd_half),
        .wr_half  (wr_half),
        .rd_map   (rd_map),
        .wr_map   (wr_map),
        .rd_bank  (rd_bank),
        .wr_bank  (wr_bank),
        .redirect (redirect)
    );

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            logic             b_rd, b_wr;
            logic [ROW_W-1:0] b_row;

            assign b_rd  = rd_en && (rd_bank == bank_t'(b));
            assign b_wr  = wr_en && (wr_bank == bank_t'(b));
            assign b_row = b_wr ? wr_row : rd_row;

            rrw_bank #(.ROW_W(ROW_W), .DATA_W(DATA_W)) bank_i (
                .clk   (clk),
                .rst   (rst),
                .en    (b_rd || b_wr),
                .we    (b_wr),
                .row   (b_row),
                .wdata (wr_data),
                .rdata (bank_rdata[b])
            );
        end
    endgenerate

    rrw_rd_route #(.DATA_W(DATA_W)) route_i (
        .clk        (clk),
        .rst        (rst),
        .rd_en      (rd_en),
        .rd_bank    (rd_bank),
        .bank_rdata (bank_rdata),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid)
    );

endmodule

// File: rtl/rrw_checker.sv
module rrw_checker
    import rrw_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic              wr_en,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input bank_t             rd_bank,
    input bank_t             wr_bank,
    input rowmap_t           wr_map
);

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (!rd_valid && $stable(rd_data))); // R7

    AST_NO_BANK_CLASH: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wr_en) |-> (rd_bank != wr_bank)); // R3

    AST_ROW_DISTINCT: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_map.lo != wr_map.hi && wr_map.lo != 2'd3 && wr_map.hi != 2'd3)); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!rd_valid && rd_data == '0)); // R5

endmodule

bind replica_rw_mem rrw_checker #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rd_bank  (rd_bank),
    .wr_bank  (wr_bank),
    .wr_map   (wr_map)
);

// File: tb/replica_rw_mem_tb_top.sv
`timescale 1ns/1ps
module replica_rw_mem_tb_top;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int WORDS  = 1 << ADDR_W;
    localparam int HALF   = WORDS / 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;

    logic [DATA_W-1:0] ref_mem [WORDS];
    logic [DATA_W-1:0] last_rd = '0;
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    replica_rw_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst(rst),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle of traffic; inputs change just after a falling edge,
    // results are sampled at the following falling edge.
    task automatic op(input logic re, input logic [ADDR_W-1:0] ra,
                      input logic we, input logic [ADDR_W-1:0] wa,
                      input logic [DATA_W-1:0] wd, input string req);
        rd_en = re; rd_addr = ra; wr_en = we; wr_addr = wa; wr_data = wd;
        @(negedge clk);
        if (re) begin
            check({req, " valid"}, DATA_W'(rd_valid), DATA_W'(1));
            check(req, rd_data, ref_mem[ra]);
            last_rd = rd_data;
        end else begin
            check("R7 valid low", DATA_W'(rd_valid), '0);
            check("R7 hold", rd_data, last_rd);
        end
        if (we) ref_mem[wa] = wd;
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R5 valid", DATA_W'(rd_valid), '0);
        check("R5 data", rd_data, '0);
        last_rd = '0;
    endtask

    task automatic t_fill_and_read();
        for (int a = 0; a < WORDS; a++)
            op(1'b0, '0, 1'b1, ADDR_W'(a), DATA_W'(32'hA500_0000 + a), "R1 fill");
        for (int a = 0; a < WORDS; a++)
            op(1'b1, ADDR_W'(a), 1'b0, '0, '0, "R1 readback");
    endtask

    task automatic t_bank_clash();
        // Fresh table: rows 5 and 9 lower halves both sit in bank 0
        op(1'b1, 8'h05, 1'b1, 8'h09, 32'h1111_0009, "R3 clash read");
        op(1'b1, 8'h09, 1'b0, '0, '0, "R3 redirected write");
        op(1'b1, 8'h89, 1'b0, '0, '0, "R6 other half intact");
        // Keep clashing on row 9 from both halves
        for (int k = 0; k < 6; k++) begin
            op(1'b1, 8'h0C, 1'b1, 8'h09, DATA_W'(32'h2200_0000 + k), "R6 clash lo");
            op(1'b1, 8'h89, 1'b0, '0, '0, "R6 hi intact");
            op(1'b1, 8'h8C, 1'b1, 8'h89, DATA_W'(32'h3300_0000 + k), "R6 clash hi");
            op(1'b1, 8'h09, 1'b0, '0, '0, "R6 lo intact");
            op(1'b1, 8'h89, 1'b1, 8'h0C, DATA_W'(32'h4400_0000 + k), "R3 cross-half");
        end
    endtask

    task automatic t_same_addr();
        op(1'b1, 8'h33, 1'b1, 8'h33, 32'hDEAD_0033, "R4 old data");
        op(1'b1, 8'h33, 1'b0, '0, '0, "R4 new data");
        op(1'b1, 8'hB3, 1'b1, 8'hB3, 32'hBEEF_00B3, "R4 old data hi");
        op(1'b1, 8'hB3, 1'b0, '0, '0, "R4 new data hi");
    endtask

    task automatic t_idle_and_nowrite();
        op(1'b1, 8'h40, 1'b0, '0, '0, "R2 read");
        op(1'b0, 8'h41, 1'b0, 8'h40, 32'hFFFF_FFFF, "R7 idle");
        op(1'b0, 8'h00, 1'b1, 8'h41, 32'h5555_0041, "R7 write only");
        // wr_en low with live-looking address and data
        rd_en = 1'b0; wr_en = 1'b0; wr_addr = 8'h40; wr_data = 32'h0BAD_0BAD;
        @(negedge clk);
        op(1'b1, 8'h40, 1'b0, 8'h40, 32'h0BAD_0BAD, "R8 no write");
        op(1'b1, 8'h41, 1'b0, '0, '0, "R1 write-only kept");
    endtask

    task automatic t_random();
        for (int k = 0; k < 3000; k++) begin
            logic [ADDR_W-1:0] ra, wa;
            logic h;
            h  = 1'($urandom_range(0, 1));
            ra = {h, (ADDR_W-1)'($urandom_range(0, 3))};
            wa = ($urandom_range(0, 3) == 0) ? ADDR_W'($urandom_range(0, WORDS-1))
                                             : {h, (ADDR_W-1)'($urandom_range(0, 3))};
            op(($urandom_range(0, 7) != 0), ra, ($urandom_range(0, 7) != 0), wa,
               DATA_W'($urandom()), "R1 R3 random");
        end
        for (int a = 0; a < WORDS; a++)
            op(1'b1, ADDR_W'(a), 1'b0, '0, '0, "R1 final sweep");
    endtask

    initial begin
        t_reset();
        t_fill_and_read();
        t_bank_clash();
        t_same_addr();
        t_idle_and_nowrite();
        t_random();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule